// File: doc/BRIEF.md
# PWM Phase Counter Timebase

This block produces the common time reference shared by a bank of pulse-width channels. A prescaler divides the core clock into beat strobes, and a 16-bit phase counter moves forward on each strobe by a power-of-two step. The step size is chosen by a resolution setting, so that one wrap of the counter always spans exactly one pulse cycle. Channels compare their own thresholds against the phase value. They use the beat strobe and the end-of-cycle strobe to update mode state such as blink and sweep counters.

Configuration arrives through simple write-enable/data ports. The divisor and the resolution can only be changed while the timebase is stopped. A sticky lock bit freezes both of them until the next reset.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous active-low reset, `phase_o` is 0, `beat_o` and `cycle_end_o` are 0, and the reset configuration is divisor 0 and resolution 0.
- R2: While `run_en` is high, `beat_o` pulses for one clock once every (divisor + 1) clocks. The first pulse appears in clock number divisor + 1 counted from the first clock with `run_en` high. A divisor of 0 gives a beat on every clock.
- R3: On each clock edge where `beat_o` is high, `phase_o` increases by 2^(15 - resolution), modulo 2^16. On all other edges while running, it holds its value.
- R4: `cycle_end_o` is high for exactly the clocks in which `beat_o` is high and `phase_o` equals 2^16 - 2^(15 - resolution). On the following edge the phase wraps to 0.
- R5: While `run_en` is low, `beat_o` and `cycle_end_o` stay 0. At each edge, both the prescaler and `phase_o` are cleared to 0.
- R6: A divisor write (`div_we`, 26-bit `div_wdata`) or a resolution write (`resn_we`, 4-bit `resn_wdata`) takes effect at the next edge only if `run_en` is low and the block is unlocked. Otherwise it has no effect.
- R7: A write of 1 on `lock_we`/`lock_wdata` sets a lock that blocks all later divisor and resolution writes. Writing 0, or writing 1 again, changes nothing. Only reset clears the lock.
- R8: A resolution value r gives 2^(r+1) beats per pulse cycle. Value 0 gives 2 beats per cycle and value 15 gives 65536 beats per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Global timebase enable |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 26 | Divisor value |
| resn_we | input | 1 | Resolution write strobe |
| resn_wdata | input | 4 | Resolution value |
| lock_we | input | 1 | Lock write strobe |
| lock_wdata | input | 1 | Lock value (1 sets the lock) |
| phase_o | output | 16 | Phase counter value |
| beat_o | output | 1 | Beat strobe |
| cycle_end_o | output | 1 | End-of-pulse-cycle strobe |

## Verification
On every cycle, the checker confirms several properties. No strobe appears while the block is stopped, and stopping clears the phase. The phase holds between beats and rises on every beat that does not wrap. An end-of-cycle strobe is always followed by phase 0, and the lock never falls outside reset.

Some behaviours can only be shown by the bench scenarios, which compare each clock against a model derived from the requirements. These are the exact beat spacing for a given divisor and the exact step size for each resolution. They also include the rejection of writes made while running or while locked, which shows up only as unchanged beat timing and unchanged phase steps.

// File: rtl/pwm_tb_pkg.sv
// Shared widths for the PWM timebase.
package pwm_tb_pkg;
    localparam int PHASE_W = 16;
    localparam int DIV_W   = 26;
    localparam int RESN_W  = $clog2(PHASE_W);
endpackage

// File: rtl/pwm_tb_cfg.sv
// Configuration holder: divisor, resolution and sticky lock.
// Assumes write strobes are single-cycle. Writes to the divisor and the
// resolution are taken only while stopped and unlocked.
module pwm_tb_cfg #(
    parameter int DIV_W  = 26,
    parameter int RESN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              resn_we,
    input  logic [RESN_W-1:0] resn_wdata,
    input  logic              lock_we,
    input  logic              lock_wdata,
    output logic [DIV_W-1:0]  div_q,
    output logic [RESN_W-1:0] resn_q,
    output logic              locked_q
);
    logic open_w;

    // A configuration write may land only when stopped and unlocked
    assign open_w = !run_en && !locked_q;

    // Hold divisor and resolution, gated by open_w
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            resn_q <= '0;
        end else begin
            if (div_we && open_w)  div_q  <= div_wdata;
            if (resn_we && open_w) resn_q <= resn_wdata;
        end
    end

    // Sticky lock, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                       locked_q <= 1'b0;
        else if (lock_we && lock_wdata)   locked_q <= 1'b1;
    end
endmodule

// File: rtl/pwm_tb_prescale.sv
// Clock prescaler: raises a beat every (div + 1) enabled clocks.
// Assumes the divisor is stable while enabled. The count is cleared when
// disabled, so the first beat comes div + 1 clocks after enable.
module pwm_tb_prescale #(
    parameter int DIV_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [DIV_W-1:0] div,
    output logic             beat
);
    logic [DIV_W-1:0] cnt_q;

    // Beat fires when the count reaches the divisor
    assign beat = run_en && (cnt_q == div);

    // Count enabled clocks, restart on each beat or when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) cnt_q <= '0;
        else if (beat)         cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_tb_phase.sv
// Phase counter: adds 2^(PHASE_W-1-resn) on each beat, modulo 2^PHASE_W.
// Assumes the phase stays a multiple of the step, which holds because the
// resolution changes only while stopped and stopping clears the phase.
module pwm_tb_phase #(
    parameter int PHASE_W = 16,
    parameter int RESN_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               beat,
    input  logic [RESN_W-1:0]  resn,
    output logic [PHASE_W-1:0] phase,
    output logic               cycle_end
);
    localparam logic [RESN_W-1:0] RESN_TOP = RESN_W'(PHASE_W - 1);

    logic [PHASE_W:0] step_w;
    logic [PHASE_W:0] sum_w;

    // Step size from resolution, with one guard bit to catch the carry
    always_comb begin
        step_w = {{PHASE_W{1'b0}}, 1'b1} << (RESN_TOP - resn);
        sum_w  = {1'b0, phase} + step_w;
    end

    // The carry out on a beat marks the last beat of the pulse cycle
    assign cycle_end = beat && sum_w[PHASE_W];

    // Advance on beats, clear when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) phase <= '0;
        else if (beat)         phase <= sum_w[PHASE_W-1:0];
    end
endmodule

// File: rtl/pwm_timebase.sv
// PWM timebase top: config holder, prescaler and phase counter.
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_timebase
    import pwm_tb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               div_we,
    input  logic [DIV_W-1:0]   div_wdata,
    input  logic               resn_we,
    input  logic [RESN_W-1:0]  resn_wdata,
    input  logic               lock_we,
    input  logic               lock_wdata,
    output logic [PHASE_W-1:0] phase_o,
    output logic               beat_o,
    output logic               cycle_end_o
);
    logic [DIV_W-1:0]  div_q;
    logic [RESN_W-1:0] resn_q;
    logic              locked_q;

    pwm_tb_cfg #(.DIV_W(DIV_W), .RESN_W(RESN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .div_we(div_we), .div_wdata(div_wdata),
        .resn_we(resn_we), .resn_wdata(resn_wdata),
        .lock_we(lock_we), .lock_wdata(lock_wdata),
        .div_q(div_q), .resn_q(resn_q), .locked_q(locked_q)
    );

    pwm_tb_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .div(div_q), .beat(beat_o)
    );

    pwm_tb_phase #(.PHASE_W(PHASE_W), .RESN_W(RESN_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .beat(beat_o),
        .resn(resn_q), .phase(phase_o), .cycle_end(cycle_end_o)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
// Cycle-level checker for pwm_timebase, attached by bind.
module pwm_timebase_chk
    import pwm_tb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               run_en,
    input logic [PHASE_W-1:0] phase_o,
    input logic               beat_o,
    input logic               cycle_end_o,
    input logic               locked_q
);
    // R5
    beat_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_o |-> run_en);
    // R5
    stop_clears_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> phase_o == '0);
    // R4
    end_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end_o |-> beat_o);
    // R4
    end_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end_o |=> phase_o == '0);
    // R3
    hold_between_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !beat_o) |=> $stable(phase_o));
    // R3
    beat_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && beat_o && !cycle_end_o) |=> phase_o > $past(phase_o));
    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);
endmodule

bind pwm_timebase pwm_timebase_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .phase_o(phase_o),
    .beat_o(beat_o), .cycle_end_o(cycle_end_o), .locked_q(locked_q)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        div_we = 1'b0;
    logic [25:0] div_wdata = '0;
    logic        resn_we = 1'b0;
    logic [3:0]  resn_wdata = '0;
    logic        lock_we = 1'b0;
    logic        lock_wdata = 1'b0;
    logic [15:0] phase_o;
    logic        beat_o;
    logic        cycle_end_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state built from the requirements
    int unsigned m_div   = 0;
    int unsigned m_step  = 32768;
    int unsigned m_cnt   = 0;
    int unsigned m_phase = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .div_we(div_we), .div_wdata(div_wdata),
        .resn_we(resn_we), .resn_wdata(resn_wdata),
        .lock_we(lock_we), .lock_wdata(lock_wdata),
        .phase_o(phase_o), .beat_o(beat_o), .cycle_end_o(cycle_end_o)
    );

    task automatic check(input bit ok, input string req, input int unsigned act,
                         input int unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: compare at mid-low phase, then advance the model past the edge
    task automatic cyc(input string req);
        bit eb, ee;
        #1;
        eb = run_en && (m_cnt == m_div);
        ee = eb && (m_phase == 65536 - m_step);
        check(beat_o == eb, {req, " beat"}, beat_o, eb);
        check(cycle_end_o == ee, {req, " cycle_end"}, cycle_end_o, ee);
        check(phase_o == m_phase[15:0], {req, " phase"}, phase_o, m_phase);
        if (!run_en) begin
            m_cnt = 0; m_phase = 0;
        end else if (eb) begin
            m_cnt = 0; m_phase = (m_phase + m_step) % 65536;
        end else m_cnt++;
        @(negedge clk);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    task automatic wr_div(input int unsigned v, input bit take, input string req);
        div_we = 1'b1; div_wdata = 26'(v);
        cyc(req);
        div_we = 1'b0;
        if (take) m_div = v;
    endtask

    task automatic wr_resn(input int unsigned r, input bit take, input string req);
        resn_we = 1'b1; resn_wdata = 4'(r);
        cyc(req);
        resn_we = 1'b0;
        if (take) m_step = 32'd1 << (15 - r);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run(3, "R1");
        rst_n = 1'b1;
        m_div = 0; m_step = 32768;
        check(phase_o == 0 && !beat_o && !cycle_end_o, "R1 idle", phase_o, 0);
    endtask

    task automatic t_fast();
        run_en = 1'b1;
        run(8, "R2 R3 R8 div0 resn0");
        run_en = 1'b0;
        run(2, "R5");
    endtask

    task automatic t_div_resn();
        wr_div(3, 1'b1, "R6 div accept");
        wr_resn(2, 1'b1, "R6 resn accept");
        run_en = 1'b1;
        run(70, "R2 R3 R4 R8 div3 resn2");
    endtask

    task automatic t_ignore_running();
        wr_div(0, 1'b0, "R6 div ignored running");
        wr_resn(0, 1'b0, "R6 resn ignored running");
        run(40, "R6 timing unchanged");
        run_en = 1'b0;
        run(3, "R5 stop clears");
    endtask

    task automatic t_fine();
        wr_div(0, 1'b1, "R6");
        wr_resn(15, 1'b1, "R8 resn15");
        run_en = 1'b1;
        run(65540, "R8 R4 65536 beats");
        run_en = 1'b0;
        run(2, "R5");
    endtask

    task automatic t_lock();
        lock_we = 1'b1; lock_wdata = 1'b0;
        cyc("R7 lock0");
        lock_we = 1'b0;
        wr_div(2, 1'b1, "R7 unlocked div write");
        wr_resn(1, 1'b1, "R7 unlocked resn write");
        lock_we = 1'b1; lock_wdata = 1'b1;
        cyc("R7 lock1");
        cyc("R7 relock");
        lock_we = 1'b0;
        wr_div(5, 1'b0, "R7 div locked");
        wr_resn(3, 1'b0, "R7 resn locked");
        run_en = 1'b1;
        run(30, "R7 config frozen");
        run_en = 1'b0;
        run(2, "R5");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fast();
        t_div_resn();
        t_ignore_running();
        t_fine();
        t_lock();
        t_reset();
        wr_div(1, 1'b1, "R1 R7 reset unlocks");
        run_en = 1'b1;
        run(10, "R1 R2 after reset");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule